// File: doc/BRIEF.md
# Bit-Serial Edit-Distance Systolic Array

The block is a linear chain of `N` identical processing elements that computes the edit distance between a stored string S of `N` nucleotides and a streamed string T of any length. Insertion and deletion cost 1 and substitution costs 2. Each element owns one column of the dynamic-programming table and keeps one character of S. That character is loaded by shifting it along the chain under a load strobe. The T characters then move through the chain one element per cycle, and each element compares them with its stored character.

Neighbouring table entries always differ by exactly one. Because of this, no element carries a full score. Each element keeps one bit for the horizontal step of its column (the previous row's entry minus its left neighbour's entry). It passes one bit for the vertical step (this row's entry minus the one above) to the next element. The update is plain AND/OR/NOT logic with no adders or comparators on scores. The last element's vertical-step bit, qualified by the forwarded valid strobe, is the block's result stream. An external counter that starts at `N` and adds +1 or -1 per strobe rebuilds the distance.

Top module: `ed_array`

## Requirements
- R1: While `clr` is high, every compute register returns to the table boundary. The chain then behaves as if the row of index 0 had just been processed, so `diff_vld` reads 0 and `diff_out` reads 1 after a clear.
- R2: Each cycle with `s_load` high shifts the stored characters one element toward the end of the chain and takes `s_char` into the first element. To hold S[0..N-1] in elements 0..N-1, S[N-1] is presented first and S[0] last, over N loads.
- R3: Characters are 2-bit codes (A=0, C=1, G=2, T=3). An element treats its stored character and the incoming T character as matching only when the codes are equal, so a T identical to S gives distance 0.
- R4: A T character presented with `t_valid` high in one cycle produces its `diff_vld` pulse exactly N clock edges later. Exactly one pulse appears per valid T character.
- R5: With the last column's entry written D(i), the bit `diff_out` for T character i is 1 when D(i) = D(i-1)+1 and 0 when D(i) = D(i-1)-1.
- R6: N plus the sum of +1 for each 1 and -1 for each 0 over a whole T stream equals the edit distance between S and T, with unit insertion and deletion cost and substitution cost 2.
- R7: Cycles with `t_valid` low change no compute state. A stream with idle gaps between characters yields the same difference bits as the same stream sent back to back.
- R8: `clr` leaves the stored S characters unchanged. After a clear, a new T stream is compared against the previously loaded S without reloading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all registers on the rising edge |
| clr | input | 1 | Synchronous clear of all compute state (not S) |
| s_load | input | 1 | Shift strobe for the stored S characters |
| s_char | input | 2 | S character entering the first element |
| t_valid | input | 1 | Qualifies `t_char`; state updates only when high |
| t_char | input | 2 | T character entering the first element |
| diff_vld | output | 1 | Valid strobe forwarded out of the last element |
| diff_out | output | 1 | Vertical-step bit of the last column (1 = +1, 0 = -1) |
| s_tail | output | 2 | Stored character of the last element (chain end) |
| t_tail | output | 2 | T character held in the last element |

## Verification
Each element adds one register stage, so a T character driven before the edge that first samples it reaches `diff_vld` after N rising edges. The bench therefore drives on falling edges and expects the pulse at exactly the N-th falling edge after the drive. The result bits are gathered on falling edges only when `diff_vld` is high. That makes gapped and back-to-back streams comparable bit for bit against a row-by-row score table that the bench computes itself. Every run ends with N+3 idle cycles before its checks, so the last pulse has drained before anything is compared.

// File: rtl/ed_pkg.sv
package ed_pkg;

  localparam int CHAR_W = 2;

  typedef logic [CHAR_W-1:0] base_t;

  localparam base_t BASE_A = 2'd0;
  localparam base_t BASE_C = 2'd1;
  localparam base_t BASE_G = 2'd2;
  localparam base_t BASE_T = 2'd3;

  // Step bits: 1 encodes +1, 0 encodes -1.
  typedef struct packed {
    logic h;  // d - c : new horizontal step of this column
    logic v;  // d - b : new vertical step handed to the next column
  } step_t;

  // The new entry d relative to the diagonal a is +2 only on a mismatch
  // with both the entry above and the entry to the left at a+1.
  function automatic logic cell_grows(input logic same, input logic h_up,
                                      input logic v_left);
    return !same && h_up && v_left;
  endfunction

  function automatic step_t ed_step(input logic same, input logic h_up,
                                    input logic v_left);
    step_t r;
    logic  g;
    g   = cell_grows(same, h_up, v_left);
    r.h = g | !v_left;
    r.v = g | !h_up;
    return r;
  endfunction

endpackage

// File: rtl/ed_cmp.sv
module ed_cmp #(
  parameter int W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq
);
  logic [W-1:0] diff_bits;

  assign diff_bits = a ^ b;
  assign eq        = ~|diff_bits;
endmodule

// File: rtl/ed_pe.sv
module ed_pe
  import ed_pkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  logic              xfer,
  input  logic [CHAR_W-1:0] s_in,
  output logic [CHAR_W-1:0] s_out,
  input  logic              vld_in,
  input  logic [CHAR_W-1:0] t_in,
  input  logic              v_in,
  output logic              vld_out,
  output logic [CHAR_W-1:0] t_out,
  output logic              v_out
);
  logic [CHAR_W-1:0] s_q;
  logic [CHAR_W-1:0] t_q;
  logic              vld_q;
  logic              h_q;
  logic              v_q;

  logic  same;
  logic  upd;
  step_t nxt;

  ed_cmp #(.W(CHAR_W)) u_cmp (
    .a (s_q),
    .b (t_in),
    .eq(same)
  );

  assign upd = vld_in && !clr;

  always_comb begin
    nxt = ed_step(same, h_q, v_in);
  end

  // Stored S character: only the load strobe moves it.
  always_ff @(posedge clk) begin
    if (xfer) begin
      s_q <= s_in;
    end
  end

  // Compute state: clear restores the top-row boundary (+1 steps).
  always_ff @(posedge clk) begin
    if (clr) begin
      t_q   <= '0;
      vld_q <= 1'b0;
      h_q   <= 1'b1;
      v_q   <= 1'b1;
    end else begin
      vld_q <= vld_in;
      if (upd) begin
        t_q <= t_in;
        h_q <= nxt.h;
        v_q <= nxt.v;
      end
    end
  end

  assign s_out   = s_q;
  assign t_out   = t_q;
  assign vld_out = vld_q;
  assign v_out   = v_q;

  // R1: a clear lands the element on the boundary state.
  a_r1_clear_boundary: assert property (@(posedge clk)
    clr |=> (h_q && v_q && !vld_q));

  // R7: without a valid character the column state holds.
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (clr)
    !vld_in |=> ($stable(h_q) && $stable(v_q) && $stable(t_q)));

  // R8: clear alone never disturbs the stored character.
  a_r8_s_kept: assert property (@(posedge clk)
    (clr && !xfer) |=> $stable(s_q));

  // R2: a load takes the neighbour's character.
  a_r2_shift: assert property (@(posedge clk)
    xfer |=> (s_q == $past(s_in)));

  // R4: the valid strobe advances one element per cycle.
  a_r4_strobe_fwd: assert property (@(posedge clk)
    !clr |=> (vld_out == $past(vld_in)));

endmodule

// File: rtl/ed_array.sv
module ed_array
  import ed_pkg::*;
#(
  parameter int N = 8
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              s_load,
  input  logic [CHAR_W-1:0] s_char,
  input  logic              t_valid,
  input  logic [CHAR_W-1:0] t_char,
  output logic              diff_vld,
  output logic              diff_out,
  output logic [CHAR_W-1:0] s_tail,
  output logic [CHAR_W-1:0] t_tail
);
  localparam int LINKS = N + 1;

  logic [CHAR_W-1:0] s_link   [LINKS];
  logic [CHAR_W-1:0] t_link   [LINKS];
  logic              vld_link [LINKS];
  logic              v_link   [LINKS];

  // Left column of the table rises by one per row.
  assign s_link[0]   = s_char;
  assign t_link[0]   = t_char;
  assign vld_link[0] = t_valid;
  assign v_link[0]   = 1'b1;

  for (genvar g = 0; g < N; g++) begin : g_pe
    ed_pe u_pe (
      .clk    (clk),
      .clr    (clr),
      .xfer   (s_load),
      .s_in   (s_link[g]),
      .s_out  (s_link[g+1]),
      .vld_in (vld_link[g]),
      .t_in   (t_link[g]),
      .v_in   (v_link[g]),
      .vld_out(vld_link[g+1]),
      .t_out  (t_link[g+1]),
      .v_out  (v_link[g+1])
    );
  end

  assign diff_vld = vld_link[N];
  assign diff_out = v_link[N];
  assign s_tail   = s_link[N];
  assign t_tail   = t_link[N];

endmodule

// File: tb/ed_array_test.sv
module ed_array_test;
  localparam int N    = 8;
  localparam int MAXT = 64;

  logic       clk;
  logic       clr;
  logic       s_load;
  logic [1:0] s_char;
  logic       t_valid;
  logic [1:0] t_char;
  logic       diff_vld;
  logic       diff_out;
  logic [1:0] s_tail;
  logic [1:0] t_tail;

  ed_array #(.N(N)) uut (
    .clk(clk), .clr(clr), .s_load(s_load), .s_char(s_char),
    .t_valid(t_valid), .t_char(t_char), .diff_vld(diff_vld),
    .diff_out(diff_out), .s_tail(s_tail), .t_tail(t_tail)
  );

  int n_tests  = 0;
  int n_failed = 0;
  bit done     = 0;

  logic [1:0] sv [N];
  logic [1:0] tv [MAXT];
  int         got [256];
  int         ng = 0;
  int         dp [MAXT+1][N+1];

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (diff_vld && ng < 256) begin
      got[ng] = int'(diff_out);
      ng = ng + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_s();
    for (int k = N - 1; k >= 0; k--) begin
      s_char = sv[k];
      s_load = 1'b1;
      @(negedge clk);
    end
    s_load = 1'b0;
  endtask

  task automatic do_clear();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic run_stream(input int len, input int gap);
    ng = 0;
    for (int i = 0; i < len; i++) begin
      t_char  = tv[i];
      t_valid = 1'b1;
      @(negedge clk);
      for (int g = 0; g < gap; g++) begin
        t_valid = 1'b0;
        @(negedge clk);
      end
    end
    t_valid = 1'b0;
    repeat (N + 3) @(negedge clk);
  endtask

  function automatic int min3(input int a, input int b, input int c);
    int m;
    m = a;
    if (b < m) m = b;
    if (c < m) m = c;
    return m;
  endfunction

  task automatic check_results(input int len, input string tag, output int recon);
    int acc;
    for (int j = 0; j <= N; j++) dp[0][j] = j;
    for (int i = 1; i <= len; i++) begin
      dp[i][0] = i;
      for (int j = 1; j <= N; j++) begin
        dp[i][j] = min3(dp[i-1][j-1] + ((sv[j-1] == tv[i-1]) ? 0 : 2),
                        dp[i-1][j] + 1, dp[i][j-1] + 1);
      end
    end
    check(ng == len, {"R4 pulse count ", tag}, ng, len);
    acc = N;
    for (int i = 1; i <= len && i <= ng; i++) begin
      int e;
      e = (dp[i][N] > dp[i-1][N]) ? 1 : 0;
      check(got[i-1] == e, {"R5 step bit ", tag}, got[i-1], e);
      acc += (got[i-1] != 0) ? 1 : -1;
    end
    check(acc == dp[len][N], {"R6 distance ", tag}, acc, dp[len][N]);
    recon = acc;
  endtask

  task automatic test_reset();
    check(diff_vld == 1'b0, "R1 reset diff_vld", int'(diff_vld), 0);
    check(diff_out == 1'b1, "R1 reset diff_out", int'(diff_out), 1);
  endtask

  task automatic test_identical();
    int r;
    for (int j = 0; j < N; j++) sv[j] = 2'($urandom_range(3, 0));
    load_s();
    for (int j = 0; j < N; j++) tv[j] = sv[j];
    do_clear();
    run_stream(N, 0);
    check_results(N, "identical", r);
    check(r == 0, "R3 identical strings distance", r, 0);
  endtask

  task automatic test_latency();
    int  k;
    bit  seen;
    do_clear();
    ng      = 0;
    t_char  = 2'd0;
    t_valid = 1'b1;
    k       = 0;
    seen    = 0;
    while (!seen && k < 3 * N) begin
      @(negedge clk);
      t_valid = 1'b0;
      k++;
      if (diff_vld) seen = 1;
    end
    check(k == N, "R4 latency in edges", k, N);
    repeat (N + 2) @(negedge clk);
  endtask

  task automatic test_random();
    int r;
    for (int it = 0; it < 12; it++) begin
      int len;
      len = 1 + $urandom_range(23, 0);
      for (int j = 0; j < N; j++) sv[j] = 2'($urandom_range(3, 0));
      for (int i = 0; i < len; i++) tv[i] = 2'($urandom_range(3, 0));
      load_s();
      do_clear();
      run_stream(len, 0);
      check_results(len, "random R2 load order", r);
    end
  endtask

  task automatic test_gaps();
    int r;
    for (int i = 0; i < 16; i++) tv[i] = 2'((i * 3 + 1) % 4);
    do_clear();
    run_stream(16, 2);
    check_results(16, "R7 gapped stream", r);
  endtask

  task automatic test_clear_keeps_s();
    int r;
    for (int i = 0; i < 12; i++) tv[i] = sv[(i + 2) % N];
    do_clear();
    run_stream(12, 0);
    check_results(12, "R8 no reload after clear", r);
  endtask

  task automatic test_all_mismatch();
    int r;
    for (int j = 0; j < N; j++) sv[j] = 2'd0;
    for (int i = 0; i < N; i++) tv[i] = 2'd1;
    load_s();
    do_clear();
    run_stream(N, 0);
    check_results(N, "all substitutions", r);
    check(r == 2 * N, "R6 substitution cost 2", r, 2 * N);
  endtask

  task automatic test_single_char();
    int r;
    for (int j = 0; j < N; j++) sv[j] = 2'(j % 4);
    load_s();
    tv[0] = 2'd2;
    do_clear();
    run_stream(1, 0);
    check_results(1, "single char", r);
    check(r == N - 1, "R2 R3 single matching char", r, N - 1);
  endtask

  initial begin
    clr     = 1'b1;
    s_load  = 1'b0;
    s_char  = 2'd0;
    t_valid = 1'b0;
    t_char  = 2'd0;
    for (int j = 0; j < N; j++) sv[j] = 2'(j % 4);
    load_s();
    repeat (2) @(negedge clk);
    clr = 1'b0;
    @(negedge clk);
    test_reset();
    test_identical();
    test_latency();
    test_random();
    test_gaps();
    test_clear_keeps_s();
    test_all_mismatch();
    test_single_char();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_failed);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++;
      n_failed++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_failed);
      $finish;
    end
  end

endmodule